// File: doc/BRIEF.md
# Interrupt Mask and Condition Unit

This block turns the upper half of a controller's status word into a 16-bit interrupt condition vector. It filters that vector through a software-held mask and drives one level-sensitive interrupt line. A small register port gives software access to the mask and to two read-only views: the raw conditions and the masked conditions. The status bits are produced elsewhere and arrive on an input bus every cycle.

The mask can be changed in three ways. It can be loaded outright. It can be OR-set through the address that reads the raw view. It can be AND-cleared through the address that reads the masked view. Because the reads and writes at those two addresses reach different storage, software can set or drop single enables without a read-modify-write. A controller-reset command clears the mask and both condition views at once. The condition views, the read data and the interrupt line are all registered.

Top module: `imcu_top`

## Requirements
- R1: Throughout reset and after it is released, the interrupt output is low and `rd_valid_o` is low. A read of the mask (offset 0) issued after release returns 0.
- R2: The raw condition view equals bits [31:16] of `status_i` as registered on the previous clock edge. A read at offset 1 returns it.
- R3: The masked condition view equals the raw view ANDed with the mask. A read at offset 2 returns it, and it never holds a bit that the raw view lacks.
- R4: `irq_o` is high exactly when the masked condition is nonzero. It changes on the first clock edge after a change of `status_i`, and on the second clock edge after a mask write is sampled.
- R5: A write at offset 0 loads the mask. A write at offset 1 ORs the data into the mask. A write at offset 2 ANDs the data into the mask. A read at offset 0 returns the mask.
- R6: Writes at offsets 1 and 2 leave the raw condition view unchanged. Reading offset 1 afterwards still returns the status bits.
- R7: A write at offset 3 clears the mask, both condition views and `irq_o` on the edge that samples it, whatever its data. On the following edge the raw view again tracks the status.
- R8: Read data appears on `rd_data_o` with `rd_valid_o` high for one cycle, on the edge after the read request is sampled. Offsets 3 and above read 0, and writes to offsets 4 and above change nothing.
- R9: Bits [15:0] of `status_i` affect neither the condition views nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_i | input | 32 | Controller status word; bits [31:16] are the conditions |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data |
| rd_valid_o | output | 1 | Read data valid, one-cycle pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
A mask bit set or cleared wrongly shows up two edges after the write. It appears at offset 0 and as a wrong masked view at offset 2. It can also appear as a missing or spurious `irq_o` whenever the matching status bit is high. A raw view that misses a status change, or one that takes in low status bits, shows up on the next read of offset 1, and through `irq_o` one edge after the status moves. A reset command that fails to clear a view shows up in the read issued right after it, before the raw view refills.

// File: rtl/imcu_pkg.sv
// Package: shared offsets and the mask-update operation type.
// Assumes a 4-bit offset space; offsets 1 and 2 must stay adjacent.
package imcu_pkg;
    parameter int unsigned ADDR_W  = 4;
    parameter logic [3:0]  OFF_MASK = 4'd0;  // read/write mask directly
    parameter logic [3:0]  OFF_RAW  = 4'd1;  // read raw view / write OR-set
    parameter logic [3:0]  OFF_MSK  = 4'd2;  // read masked view / write AND-clear
    parameter logic [3:0]  OFF_CLR  = 4'd3;  // write: controller reset command

    typedef enum logic [2:0] {
        MOP_HOLD  = 3'd0,
        MOP_LOAD  = 3'd1,
        MOP_SET   = 3'd2,
        MOP_AND   = 3'd3,
        MOP_CLEAR = 3'd4
    } mask_op_e;
endpackage

// File: rtl/imcu_mask_reg.sv
// Mask register with load, OR-set, AND and clear updates.
// Assumes exactly one operation per cycle, chosen by the decoder.
module imcu_mask_reg
    import imcu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mask_op_e     op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    logic [W-1:0] mask_d;

    // Per-bit next-state cell: each bit picks its update from the operation.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            unique case (op)
                MOP_LOAD:  mask_d[b] = wdata[b];
                MOP_SET:   mask_d[b] = mask_q[b] | wdata[b];
                MOP_AND:   mask_d[b] = mask_q[b] & wdata[b];
                MOP_CLEAR: mask_d[b] = 1'b0;
                default:   mask_d[b] = mask_q[b];
            endcase
        end
    end

    // Mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // R5: OR-set never drops a bit and always sets the written ones.
    p_or_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_SET) |=> (((mask_q & $past(wdata)) == $past(wdata)) &&
                             (($past(mask_q) & ~mask_q) == '0)));
    // R5: AND-clear never raises a bit and leaves no bit outside the data.
    p_and_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_AND) |=> (((mask_q & ~$past(wdata)) == '0) &&
                             ((mask_q & ~$past(mask_q)) == '0)));
    // R7: the clear command empties the mask.
    p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_CLEAR) |=> (mask_q == '0));
endmodule

// File: rtl/imcu_cond_eval.sv
// Registers the raw and masked condition views and the interrupt level.
// Assumes the condition field is the top COND_W bits of the status word.
module imcu_cond_eval #(
    parameter int unsigned STAT_W = 32,
    parameter int unsigned COND_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status,
    input  logic [COND_W-1:0] mask_q,
    input  logic              clr,
    output logic [COND_W-1:0] raw_q,
    output logic [COND_W-1:0] msk_q,
    output logic              irq_q
);
    localparam int unsigned COND_LSB = STAT_W - COND_W;

    logic [COND_W-1:0] cond_hi;
    logic [COND_W-1:0] cond_en;

    // Extract the condition field and gate it with the mask.
    always_comb begin
        cond_hi = status[STAT_W-1:COND_LSB];
        cond_en = cond_hi & mask_q;
    end

    // Condition views and interrupt level, cleared by the reset command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            raw_q <= '0;
            msk_q <= '0;
            irq_q <= 1'b0;
        end else begin
            raw_q <= cond_hi;
            msk_q <= cond_en;
            irq_q <= |cond_en;
        end
    end

    // R2: raw view follows the status field one edge later.
    p_raw_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (raw_q == $past(status[STAT_W-1:COND_LSB])));
    // R3: the masked view is a subset of the raw view.
    p_masked_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q & ~raw_q) == '0);
    // R4: interrupt level agrees with the masked view.
    p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (msk_q != '0));
    // R7: the clear command empties both views and drops the line.
    p_views_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (raw_q == '0 && msk_q == '0 && !irq_q));
endmodule

// File: rtl/imcu_read_port.sv
// Registered read multiplexer over mask and condition views.
// Assumes one read at most per cycle; unmapped offsets return zero.
module imcu_read_port
    import imcu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      mask_q,
    input  logic [W-1:0]      raw_q,
    input  logic [W-1:0]      msk_q,
    output logic [W-1:0]      rd_data,
    output logic              rd_valid
);
    logic [W-1:0] sel;

    // Select the view addressed by the read.
    always_comb begin
        unique case (addr)
            OFF_MASK: sel = mask_q;
            OFF_RAW:  sel = raw_q;
            OFF_MSK:  sel = msk_q;
            default:  sel = '0;
        endcase
    end

    // Capture read data and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= sel;
        end
    end

    // R8: every read request yields a valid pulse on the next edge.
    p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    // R8: unmapped reads return zero.
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && addr > OFF_MSK) |=> (rd_data == '0));
endmodule

// File: rtl/imcu_top.sv
// Interrupt mask and condition unit: decodes register accesses,
// holds the mask and drives one registered level interrupt.
// Assumes single-cycle requests and a status word that is valid every cycle.
module imcu_top
    import imcu_pkg::*;
#(
    parameter int unsigned STAT_W = 32,
    parameter int unsigned COND_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [COND_W-1:0] wdata_i,
    output logic [COND_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              irq_o
);
    mask_op_e          op;
    logic              clr;
    logic              rd_req;
    logic [COND_W-1:0] mask_q;
    logic [COND_W-1:0] raw_q;
    logic [COND_W-1:0] msk_q;

    // Write decode: the offset picks the mask operation.
    always_comb begin
        op     = MOP_HOLD;
        clr    = 1'b0;
        rd_req = req_i && !we_i;
        if (req_i && we_i) begin
            unique case (addr_i)
                OFF_MASK: op = MOP_LOAD;
                OFF_RAW:  op = MOP_SET;
                OFF_MSK:  op = MOP_AND;
                OFF_CLR:  begin op = MOP_CLEAR; clr = 1'b1; end
                default:  op = MOP_HOLD;
            endcase
        end
    end

    imcu_mask_reg #(.W(COND_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(wdata_i), .mask_q(mask_q)
    );

    imcu_cond_eval #(.STAT_W(STAT_W), .COND_W(COND_W)) u_cond (
        .clk(clk), .rst_n(rst_n), .status(status_i), .mask_q(mask_q),
        .clr(clr), .raw_q(raw_q), .msk_q(msk_q), .irq_q(irq_o)
    );

    imcu_read_port #(.W(COND_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .addr(addr_i),
        .mask_q(mask_q), .raw_q(raw_q), .msk_q(msk_q),
        .rd_data(rd_data_o), .rd_valid(rd_valid_o)
    );

    // R1: nothing is pending in the cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !rd_valid_o));
    // R6: OR/AND writes never touch the raw view beyond normal tracking.
    p_view_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && (op == MOP_SET || op == MOP_AND))
            |=> (raw_q == $past(status_i[STAT_W-1:STAT_W-COND_W])));
endmodule

// File: tb/tb_imcu_top.sv
`timescale 1ns/100ps
module tb_imcu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] status = '0;
    logic        req = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid, irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    imcu_top dut (
        .clk(clk), .rst_n(rst_n), .status_i(status), .req_i(req), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data),
        .rd_valid_o(rd_valid), .irq_o(irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        req = 1; we = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        req = 0; we = 0;
    endtask

    // Driver: issue a read and push the expected value to the scoreboard.
    task automatic reg_rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        req = 1; we = 0; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1;
        req = 0;
    endtask

    // Monitor: pop and compare each returned read.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R8: unexpected read data %h expected none", rd_data);
            end else begin
                chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk({15'd0, irq}, 16'd0, "R1 irq in reset");
        chk({15'd0, rd_valid}, 16'd0, "R1 rd_valid in reset");
        @(posedge clk); #1 rst_n = 1;
        idle(2);
        chk({15'd0, irq}, 16'd0, "R1 irq after reset");
        reg_rd(4'd0, 16'h0000, "R1 mask after reset");

        status = 32'hABCD_1234; idle(3);
        reg_rd(4'd1, 16'hABCD, "R2 raw view");
        reg_rd(4'd2, 16'h0000, "R3 masked with zero mask");
        chk({15'd0, irq}, 16'd0, "R4 irq low with zero mask");

        reg_wr(4'd0, 16'h00F0); idle(3);
        reg_rd(4'd0, 16'h00F0, "R5 direct load");
        reg_rd(4'd2, 16'h00C0, "R3 masked after load");
        chk({15'd0, irq}, 16'd1, "R4 irq high");

        reg_wr(4'd1, 16'h0003); idle(3);
        reg_rd(4'd0, 16'h00F3, "R5 OR-set");
        reg_rd(4'd1, 16'hABCD, "R6 raw unchanged after OR write");
        reg_wr(4'd2, 16'h0F0F); idle(3);
        reg_rd(4'd0, 16'h0003, "R5 AND-clear");
        reg_rd(4'd2, 16'h0001, "R3 masked after AND");
        reg_rd(4'd1, 16'hABCD, "R6 raw unchanged after AND write");

        status = 32'hABCD_FFFF; idle(3);
        reg_rd(4'd1, 16'hABCD, "R9 low status bits ignored");
        chk({15'd0, irq}, 16'd1, "R9 irq unchanged by low bits");

        // R4 latency after status change: one edge.
        @(posedge clk); #1 status = 32'h0000_FFFF;
        chk({15'd0, irq}, 16'd1, "R4 irq before edge");
        @(posedge clk); #1;
        chk({15'd0, irq}, 16'd0, "R4 irq one edge after status");

        // R4 latency after mask write: two edges.
        status = 32'h0001_0000; reg_wr(4'd0, 16'h0000); idle(2);
        chk({15'd0, irq}, 16'd0, "R4 irq with mask zero");
        @(posedge clk); #1 req = 1; we = 1; addr = 4'd1; wdata = 16'h0001;
        @(posedge clk); #1 req = 0; we = 0;
        chk({15'd0, irq}, 16'd0, "R4 irq one edge after mask write");
        @(posedge clk); #1;
        chk({15'd0, irq}, 16'd1, "R4 irq two edges after mask write");

        // R7 reset command.
        status = 32'hFFFF_0000; reg_wr(4'd0, 16'hFFFF); idle(3);
        chk({15'd0, irq}, 16'd1, "R7 irq high before clear");
        @(posedge clk); #1 req = 1; we = 1; addr = 4'd3; wdata = 16'h1234;
        @(posedge clk); #1 we = 0; addr = 4'd1;
        chk({15'd0, irq}, 16'd0, "R7 irq cleared");
        exp_q.push_back(16'h0000); tag_q.push_back("R7 raw view cleared");
        @(posedge clk); #1 req = 0;
        idle(2);
        reg_rd(4'd0, 16'h0000, "R7 mask cleared");
        reg_rd(4'd1, 16'hFFFF, "R7 raw tracks again");
        chk({15'd0, irq}, 16'd0, "R7 irq stays low");

        // R8 unmapped offsets.
        reg_rd(4'd5, 16'h0000, "R8 unmapped read");
        reg_rd(4'd3, 16'h0000, "R8 command offset reads zero");
        reg_wr(4'd7, 16'hFFFF); idle(3);
        reg_rd(4'd0, 16'h0000, "R8 unmapped write ignored");
        chk({15'd0, irq}, 16'd0, "R8 irq after unmapped write");

        idle(4);
        chk(16'(exp_q.size()), 16'd0, "R8 all reads answered");
        finish_run();
    end
endmodule